// File: doc/BRIEF.md
# Trimmed one-second real-time clock

The block turns a slow reference enable (nominally a 32.768 kHz strobe, sampled in the system clock domain) into a one-second event and counts those events in a 32-bit seconds register. A single register holds both the divide count and a periodic correction value. The correction stretches one second out of every 1024 by a programmable number of reference cycles, so a reference that runs slightly fast can be pulled back into step over the long run.

A 32-bit alarm register is compared with the seconds count. When alarm matching is enabled and the count takes the alarm value, a sticky flag is set and an interrupt is raised. Software reaches all state through a small word-addressed register bus. Writes take effect on the clock edge. Reads return data combinationally from the selected register.

Register map (addr_i): 0 = seconds count, 1 = alarm value, 2 = period register (divide count in bits [15:0], trim in bits [25:16]), 3 = status (bit 0 alarm enable, bit 1 alarm flag).

Top module: `rtc_trim_clock`

## Requirements
- R1: After reset, the seconds count, alarm value, period register and status all read as zero, and irq_o is low.
- R2: With a nonzero divide count N in period bits [15:0], the seconds count rises by exactly one on every (N+1)-th clock edge that has tick_en_i high. Edges with tick_en_i low do not advance the count.
- R3: While period bits [15:0] are zero, the block divides by the default count 32767, so a tick arrives after 32768 enabled edges.
- R4: A trim value T in period bits [25:16] lengthens the 1024th second after a prescaler restart, and every 1024th second after that, to N+1+T enabled edges. All other seconds keep N+1.
- R5: A write to address 0 loads the seconds count with the written value. It also restarts the prescaler and the 1024-second trim interval, so the next tick comes a full N+1 enabled edges later.
- R6: The alarm value at address 1 is a 32-bit register that reads back what was written.
- R7: When the seconds count takes a new value equal to the alarm value, whether by a tick or by a write, and status bit 0 (enable) is set, status bit 1 (flag) becomes set. No flag is set while enable is clear.
- R8: Writing 1 to status bit 1 clears the flag. Writing 0 to it leaves the flag unchanged. Status bit 0 takes the written value.
- R9: irq_o is high exactly when the status flag and the status enable are both set.
- R10: The period register stores bits [25:0] of a write, and bits [31:26] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Reference-cycle strobe, one pulse per 32 kHz period |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The divider is driven with a table of divide counts and run lengths. Each run stops either one enable short of a tick or exactly on it, so an off-by-one in the reload shows as a count that is wrong by one second. A gapped enable pattern shows that only strobed edges count. Separate runs cover:
- the zero-field default divide, timed across its full 32768 edges;
- a trimmed run crossing the 1024th second, which separates a stretched period from a normal one;
- a restart in the middle of a period.

The alarm is reached once by ticking and once by a bus write, and once more with enable clear. The flag is then cleared with a zero and with a one in bit 1, and gated by enable, which together separate the set, clear and masking paths.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_SECS   = 2'd0,
    REG_ALARM  = 2'd1,
    REG_PERIOD = 2'd2,
    REG_STATUS = 2'd3
  } rtc_reg_e;

  localparam int STS_EN_BIT   = 0;
  localparam int STS_FLAG_BIT = 1;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W    = 16,
  parameter int TRIM_W   = 10,
  parameter int TRIM_LOG = 10,
  parameter int DEF_DIV  = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              tick_o
);
  localparam int PRE_W = DIV_W + 1;

  logic [PRE_W-1:0]    pre_q;
  logic [TRIM_LOG-1:0] seg_q;
  logic [DIV_W-1:0]    base;
  logic [PRE_W-1:0]    limit;
  logic                last_seg;
  logic                reach;

  assign base     = (div_i == '0) ? DIV_W'(DEF_DIV) : div_i;
  assign last_seg = &seg_q;
  // one second in each trim interval is stretched by the trim count
  assign limit    = {1'b0, base} + (last_seg ? PRE_W'(trim_i) : '0);
  assign reach    = (pre_q >= limit);
  assign tick_o   = en_i & ~restart_i & reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      seg_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
      seg_q <= '0;
    end else if (en_i) begin
      if (reach) begin
        pre_q <= '0;
        seg_q <= seg_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              upd_o,
  output logic [DATA_W-1:0] nxt_o
);
  logic [DATA_W-1:0] cnt_q;

  assign upd_o = tick_i | load_i;
  assign nxt_o = load_i ? load_val_i : cnt_q + 1'b1;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (upd_o) cnt_q <= nxt_o;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alarm_wr_i,
  input  logic              status_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] nxt_i,
  output logic [DATA_W-1:0] alarm_o,
  output logic              en_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] alarm_q;
  logic              en_q;
  logic              flag_q;
  logic              hit;

  // event on the update that lands on the alarm value, not on the level
  assign hit = en_q & upd_i & (nxt_i == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      en_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (alarm_wr_i)  alarm_q <= wdata_i;
      if (status_wr_i) en_q    <= wdata_i[STS_EN_BIT];
      if (hit)         flag_q  <= 1'b1;
      else if (status_wr_i && wdata_i[STS_FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  assign alarm_o = alarm_q;
  assign en_o    = en_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/rtc_trim_clock.sv
module rtc_trim_clock
  import rtc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 16,
  parameter int TRIM_W   = 10,
  parameter int TRIM_LOG = 10,
  parameter int DEF_DIV  = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PER_W = DIV_W + TRIM_W;

  logic              wr_secs, wr_alarm, wr_period, wr_status;
  logic [PER_W-1:0]  period_q;
  logic              tick;
  logic [DATA_W-1:0] sec_q;
  logic              upd;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] alarm_q;
  logic              alarm_en;
  logic              alarm_flag;

  assign wr_secs   = wr_i & (addr_i == REG_SECS);
  assign wr_alarm  = wr_i & (addr_i == REG_ALARM);
  assign wr_period = wr_i & (addr_i == REG_PERIOD);
  assign wr_status = wr_i & (addr_i == REG_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        period_q <= '0;
    else if (wr_period) period_q <= wdata_i[PER_W-1:0];
  end

  rtc_prescaler #(
    .DIV_W   (DIV_W),
    .TRIM_W  (TRIM_W),
    .TRIM_LOG(TRIM_LOG),
    .DEF_DIV (DEF_DIV)
  ) u_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tick_en_i),
    .restart_i(wr_secs),
    .div_i    (period_q[DIV_W-1:0]),
    .trim_i   (period_q[PER_W-1:DIV_W]),
    .tick_o   (tick)
  );

  rtc_seconds #(.DATA_W(DATA_W)) u_seconds (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (wr_secs),
    .load_val_i(wdata_i),
    .cnt_o     (sec_q),
    .upd_o     (upd),
    .nxt_o     (nxt)
  );

  rtc_alarm #(.DATA_W(DATA_W)) u_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alarm_wr_i (wr_alarm),
    .status_wr_i(wr_status),
    .wdata_i    (wdata_i),
    .upd_i      (upd),
    .nxt_i      (nxt),
    .alarm_o    (alarm_q),
    .en_o       (alarm_en),
    .flag_o     (alarm_flag)
  );

  always_comb begin
    unique case (addr_i)
      REG_SECS:   rdata_o = sec_q;
      REG_ALARM:  rdata_o = alarm_q;
      REG_PERIOD: rdata_o = DATA_W'(period_q);
      default:    rdata_o = DATA_W'({alarm_flag, alarm_en});
    endcase
  end

  assign irq_o = alarm_flag & alarm_en;
endmodule

// File: rtl/rtc_trim_clock_chk.sv
module rtc_trim_clock_chk
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_en_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              tick,
  input logic [DATA_W-1:0] sec_q,
  input logic              upd,
  input logic [DATA_W-1:0] nxt,
  input logic [DATA_W-1:0] alarm_q,
  input logic              alarm_en,
  input logic              alarm_flag
);
  logic wsec, wsts, hit;
  assign wsec = wr_i && addr_i == REG_SECS;
  assign wsts = wr_i && addr_i == REG_STATUS;
  assign hit  = upd && nxt == alarm_q && alarm_en;

  AST_TICK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> tick_en_i); // R2
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> sec_q == $past(sec_q) + 1'b1); // R2
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !wsec) |=> $stable(sec_q)); // R2
  AST_SEC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wsec |=> sec_q == $past(wdata_i)); // R5
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> alarm_flag); // R7
  AST_FLAG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_flag && !alarm_en) |=> !alarm_flag); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsts && wdata_i[STS_FLAG_BIT] && !hit) |=> !alarm_flag); // R8
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (alarm_en && alarm_flag)); // R9
endmodule

bind rtc_trim_clock rtc_trim_clock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_en_i (tick_en_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .tick      (tick),
  .sec_q     (sec_q),
  .upd       (upd),
  .nxt       (nxt),
  .alarm_q   (alarm_q),
  .alarm_en  (alarm_en),
  .alarm_flag(alarm_flag)
);

// File: tb/rtc_trim_clock_bench.sv
`timescale 1ns/1ps
module rtc_trim_clock_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  rtc_trim_clock u_rtc_trim_clock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_en_i(tick_en_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
  );

  // divide count, enabled edges, expected seconds
  localparam int VEC_N = 8;
  localparam int VEC [VEC_N][3] = '{
    '{1, 2, 1}, '{1, 7, 3}, '{4, 4, 0}, '{4, 5, 1},
    '{9, 30, 3}, '{2, 9, 3}, '{15, 47, 2}, '{15, 48, 3}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic run_en(int k);
    @(negedge clk_i);
    tick_en_i = 1'b1;
    repeat (k) @(negedge clk_i);
    tick_en_i = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    #20;
    @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1", v, 32'd0);
    end
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;

    // R3 default divide with zero field
    run_en(32767);
    rd(2'd0, v); check("R3 before", v, 32'd0);
    run_en(1);
    rd(2'd0, v); check("R3 tick", v, 32'd1);

    // R2 table
    for (int i = 0; i < VEC_N; i++) begin
      wr(2'd2, 32'(VEC[i][0]));
      wr(2'd0, 32'd0);
      run_en(VEC[i][1]);
      rd(2'd0, v);
      check("R2 table", v, 32'(VEC[i][2]));
    end

    // R2 gapped strobe
    wr(2'd2, 32'd2);
    wr(2'd0, 32'd0);
    for (int i = 0; i < 6; i++) begin
      run_en(1);
      repeat (2) @(negedge clk_i);
    end
    rd(2'd0, v); check("R2 gapped", v, 32'd2);

    // R10 period width
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R10", v, 32'h03FF_FFFF);

    // R4 trim: N=1, T=5
    wr(2'd2, (32'd5 << 16) | 32'd1);
    wr(2'd0, 32'd0);
    run_en(2046);
    rd(2'd0, v); check("R4 normal", v, 32'd1023);
    run_en(6);
    rd(2'd0, v); check("R4 stretched", v, 32'd1023);
    run_en(1);
    rd(2'd0, v); check("R4 stretched end", v, 32'd1024);
    run_en(2);
    rd(2'd0, v); check("R4 back to normal", v, 32'd1025);

    // R5 restart mid-period, N=4
    wr(2'd2, 32'd4);
    wr(2'd0, 32'd100);
    rd(2'd0, v); check("R5 load", v, 32'd100);
    run_en(3);
    wr(2'd0, 32'd200);
    run_en(4);
    rd(2'd0, v); check("R5 full period", v, 32'd200);
    run_en(1);
    rd(2'd0, v); check("R5 tick", v, 32'd201);

    // R6 alarm readback
    wr(2'd1, 32'hA5C3_0F01);
    rd(2'd1, v); check("R6", v, 32'hA5C3_0F01);

    // R7 by tick, N=1
    wr(2'd2, 32'd1);
    wr(2'd1, 32'd5);
    wr(2'd3, 32'd1);
    wr(2'd0, 32'd3);
    run_en(2);
    rd(2'd3, v); check("R7 not yet", v, 32'd1);
    check("R9 low", {31'd0, irq_o}, 32'd0);
    run_en(2);
    rd(2'd0, v); check("R7 count", v, 32'd5);
    rd(2'd3, v); check("R7 set by tick", v, 32'd3);
    check("R9 high", {31'd0, irq_o}, 32'd1);
    // R8 clear semantics
    wr(2'd3, 32'd1);
    rd(2'd3, v); check("R8 zero keeps", v, 32'd3);
    wr(2'd3, 32'd3);
    rd(2'd3, v); check("R8 one clears", v, 32'd1);
    // R7 disabled
    wr(2'd3, 32'd0);
    wr(2'd0, 32'd5);
    rd(2'd3, v); check("R7 disabled", v, 32'd0);
    // R7 by write
    wr(2'd3, 32'd1);
    wr(2'd0, 32'd5);
    rd(2'd3, v); check("R7 set by write", v, 32'd3);
    // R9 gating
    wr(2'd3, 32'd0);
    rd(2'd3, v); check("R9 flag kept", v, 32'd2);
    check("R9 masked", {31'd0, irq_o}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule